// File: doc/BRIEF.md
# Interrupt Gate and Keyed Core Reset

This wrapper collects single-cycle event pulses from a peripheral core and turns them into one level interrupt. Each event source has a sticky pending flag. A per-source mask and a master gate decide whether a pending flag reaches the interrupt pin. Software clears pending flags by writing ones to them, so it can write back the value it just read.

The same register window holds a keyed reset control. Writing one exact key word to it drives a reset pulse of fixed length into the attached core. The same write clears the wrapper's own masks, master gate and pending flags, so every interrupt is off afterwards.

The bus side is a simple strobe interface: one write strobe, one read strobe, a byte address and a data word. Read data appears one cycle after the read strobe.

Top module: `irq_reset_wrap`

## Requirements
- R1: After the reset input is released, every mapped register reads 0, `irq_o` is 0 and `core_rst_o` is 0.
- R2: Registers sit at byte offsets 0x1C (master gate), 0x20 (pending flags), 0x28 (source mask) and 0x40 (keyed reset). `rdata` holds the selected value in the cycle after `rd_en`. The keyed reset register and any unmapped offset read 0. The mask register reads back bits 6:0 as written.
- R3: Event bit i sets pending flag i whether or not mask bit i is set. The bit order of `evt_i` and of both the mask and pending registers is: 0 mode fault, 1 select-while-disabled fault, 2 transmit empty, 3 transmit underrun, 4 receive full, 5 receive overrun, 6 transmit half empty. A pending flag stays set until it is cleared.
- R4: A write to offset 0x20 clears exactly the pending flags whose data bit is 1. Flags whose data bit is 0 are left as they are, and data bits above bit 6 are ignored.
- R5: If an event arrives in the same cycle as a clearing write to the same flag, the flag stays set.
- R6: `irq_o` is a registered, active-high level. In the cycle after a state change it equals master gate AND (OR over all pending flags that have their mask bit set).
- R7: Only bit 31 of the master gate register is stored. Writing 0x80000000 or any word with bit 31 set enables the gate, and any word with bit 31 clear disables it. The register reads back with only bit 31 possibly set.
- R8: Writing exactly 0x0000000A to offset 0x40 raises `core_rst_o` for exactly 16 cycles, starting in the cycle after the write. The same write clears the master gate, the source mask and the pending flags.
- R9: Writing any other value to offset 0x40, or writing 0x0000000A to any other offset, leaves `core_rst_o` low and the register state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle after `rd_en` |
| evt_i | input | 7 | Event pulses from the core, one bit per source |
| core_rst_o | output | 1 | Reset pulse to the attached core |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
The main path is driven with several patterns. Events arrive with their mask bit clear and with it set, which shows that latching does not depend on the mask. The master gate is toggled with its top bit and with every other bit, which shows that only bit 31 counts. Partial clearing writes and clearing writes with bits above the source field show that clearing is selective. An event that lands in the same cycle as its own clear shows which side wins. For the keyed reset, near-miss values and the key sent to the wrong offset are checked against the exact key: the pulse length and the cleared registers are observed only in the exact-key case.

// File: rtl/irq_wrap_pkg.sv
package irq_wrap_pkg;

  localparam int unsigned NUM_REGS = 4;

  typedef enum logic [1:0] {
    REG_GATE = 2'd0,
    REG_PEND = 2'd1,
    REG_MASK = 2'd2,
    REG_KRST = 2'd3
  } reg_idx_e;

  localparam logic [7:0] OFS_GATE = 8'h1C;
  localparam logic [7:0] OFS_PEND = 8'h20;
  localparam logic [7:0] OFS_MASK = 8'h28;
  localparam logic [7:0] OFS_KRST = 8'h40;

  localparam logic [31:0] KRST_KEY = 32'h0000_000A;

  function automatic logic [7:0] reg_offset(input int unsigned idx);
    logic [7:0] ofs;
    case (idx)
      0:       ofs = OFS_GATE;
      1:       ofs = OFS_PEND;
      2:       ofs = OFS_MASK;
      default: ofs = OFS_KRST;
    endcase
    return ofs;
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_wrap_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  output logic [NUM_REGS-1:0] wr_sel_o,
  output logic [NUM_REGS-1:0] rd_sel_o
);

  logic [NUM_REGS-1:0] hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit[g] = (addr_i == ADDR_W'(reg_offset(g)));
  end

  always_comb begin
    wr_sel_o = hit & {NUM_REGS{wr_en_i}};
    rd_sel_o = hit & {NUM_REGS{rd_en_i}};
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wipe_i,
  input  logic            clr_wr_i,
  input  logic [NSRC-1:0] clr_mask_i,
  input  logic [NSRC-1:0] evt_i,
  output logic [NSRC-1:0] pend_o
);

  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] pend_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    logic clr_bit;
    assign clr_bit = wipe_i | (clr_wr_i & clr_mask_i[g]);

    always_comb begin
      pend_d[g] = pend_q[g];
      if (clr_bit) pend_d[g] = 1'b0;
      if (evt_i[g] && !wipe_i) pend_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_d[g];
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/krst_pulse.sv
module krst_pulse #(
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic busy_o
);

  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;

  always_comb begin
    cnt_en = fire_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (fire_i)              cnt_d = CNT_W'(PULSE_CYC);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/irq_reset_wrap.sv
module irq_reset_wrap
  import irq_wrap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NSRC      = 7,
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSRC-1:0]   evt_i,
  output logic              core_rst_o,
  output logic              irq_o
);

  localparam int unsigned GATE_BIT = DATA_W - 1;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [NUM_REGS-1:0] wr_sel;
  logic [NUM_REGS-1:0] rd_sel;

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr),
    .wr_en_i  (wr_en),
    .rd_en_i  (rd_en),
    .wr_sel_o (wr_sel),
    .rd_sel_o (rd_sel)
  );

  logic key_wr;
  assign key_wr = wr_sel[REG_KRST] && (wdata == DATA_W'(KRST_KEY));

  // master gate and source mask
  logic            gate_d, gate_q, gate_en;
  logic [NSRC-1:0] mask_d, mask_q;
  logic            mask_en;

  always_comb begin
    gate_en = key_wr || wr_sel[REG_GATE];
    gate_d  = key_wr ? 1'b0 : wdata[GATE_BIT];
    mask_en = key_wr || wr_sel[REG_MASK];
    mask_d  = key_wr ? '0 : wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      gate_q <= 1'b0;
      mask_q <= '0;
    end else begin
      if (gate_en) gate_q <= gate_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  logic [NSRC-1:0] pend;

  irq_pend_bank #(.NSRC(NSRC)) u_pend (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .wipe_i     (key_wr),
    .clr_wr_i   (wr_sel[REG_PEND]),
    .clr_mask_i (wdata[NSRC-1:0]),
    .evt_i      (evt_i),
    .pend_o     (pend)
  );

  krst_pulse #(.PULSE_CYC(PULSE_CYC)) u_krst (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .fire_i (key_wr),
    .busy_o (core_rst_o)
  );

  // registered interrupt level
  logic irq_d, irq_q;
  assign irq_d = gate_q && (|(pend & mask_q));

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  // registered read path
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rdata_en;

  always_comb begin
    rdata_en = rd_en;
    rdata_d  = '0;
    if (rd_sel[REG_GATE]) rdata_d[GATE_BIT] = gate_q;
    if (rd_sel[REG_PEND]) rdata_d[NSRC-1:0] = pend;
    if (rd_sel[REG_MASK]) rdata_d[NSRC-1:0] = mask_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)      rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end
  assign rdata = rdata_q;

endmodule

// File: rtl/irq_wrap_chk.sv
module irq_wrap_chk
  import irq_wrap_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NSRC   = 7
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [NSRC-1:0]   evt_i,
  input logic              core_rst_o,
  input logic              irq_o,
  input logic              gate_q,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   pend
);

  logic to_krst, key_hit;
  assign to_krst = wr_en && (addr == ADDR_W'(OFS_KRST));
  assign key_hit = to_krst && (wdata == DATA_W'(KRST_KEY));

  // R6: interrupt only follows an enabled pending flag under the gate
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_o |-> $past(gate_q && (|(pend & mask_q))));

  // R3: no pending flag appears without its event
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(evt_i)) == '0));

  // R5: an event always lands, even against a clearing write
  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    ((evt_i != '0) && !key_hit) |=> ((pend & $past(evt_i)) == $past(evt_i)));

  // R8: the key write starts the pulse and clears gate and mask
  assert_key_clears_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    key_hit |=> (core_rst_o && !gate_q && (mask_q == '0) && (pend == '0)));

  // R9: a wrong value at the key register starts nothing
  assert_bad_key_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (to_krst && !key_hit && !core_rst_o) |=> !core_rst_o);

  // R8: the pulse only begins after a key write
  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(core_rst_o) |-> $past(key_hit));

endmodule

bind irq_reset_wrap irq_wrap_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NSRC   (NSRC)
) u_chk (
  .clk        (clk),
  .rst_ok     (rst_s_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .evt_i      (evt_i),
  .core_rst_o (core_rst_o),
  .irq_o      (irq_o),
  .gate_q     (gate_q),
  .mask_q     (mask_q),
  .pend       (pend)
);

// File: tb/irq_reset_wrap_test.sv
module irq_reset_wrap_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [6:0]  evt_i;
  logic        core_rst_o, irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_reset_wrap uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_i(evt_i),
    .core_rst_o(core_rst_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  ofs;
    logic [31:0] dat;
    logic [6:0]  evt;
    logic [6:0]  exp_pend;
    logic        exp_irq;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'h00, 32'h0000_0000, 7'h05, 7'h05, 1'b0},
    '{1'b1, 8'h28, 32'h0000_0004, 7'h00, 7'h05, 1'b0},
    '{1'b1, 8'h1C, 32'h8000_0000, 7'h00, 7'h05, 1'b1},
    '{1'b1, 8'h1C, 32'h7FFF_FFFF, 7'h00, 7'h05, 1'b0},
    '{1'b1, 8'h1C, 32'h8000_0000, 7'h00, 7'h05, 1'b1},
    '{1'b1, 8'h20, 32'h0000_0004, 7'h00, 7'h01, 1'b0},
    '{1'b1, 8'h28, 32'h0000_0001, 7'h00, 7'h01, 1'b1},
    '{1'b1, 8'h20, 32'h0000_0001, 7'h01, 7'h01, 1'b1},
    '{1'b1, 8'h20, 32'h0000_0001, 7'h00, 7'h00, 1'b0},
    '{1'b0, 8'h00, 32'h0000_0000, 7'h40, 7'h40, 1'b0},
    '{1'b1, 8'h28, 32'h0000_007F, 7'h00, 7'h40, 1'b1},
    '{1'b1, 8'h40, 32'h0000_000B, 7'h00, 7'h40, 1'b1},
    '{1'b1, 8'h20, 32'hFFFF_FF80, 7'h00, 7'h40, 1'b1},
    '{1'b0, 8'h00, 32'h0000_0000, 7'h3F, 7'h7F, 1'b1},
    '{1'b1, 8'h20, 32'h0000_007F, 7'h00, 7'h00, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [6:0] e);
    wr_en = w; addr = a; wdata = d; evt_i = e;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h00; wdata = '0; evt_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    v = rdata;
    rd_en = 1'b0; addr = 8'h00;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int n;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 core_rst", {31'b0, core_rst_o}, 32'h0);
    rd(8'h1C, v); check("R1 gate", v, 32'h0);
    rd(8'h20, v); check("R1 pend", v, 32'h0);
    rd(8'h28, v); check("R1 mask", v, 32'h0);
    rd(8'h40, v); check("R1 key reg", v, 32'h0);

    // table: R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].wr, VEC[i].ofs, VEC[i].dat, VEC[i].evt);
      rd(8'h20, v);
      check($sformatf("R3/R4/R5 pend row %0d", i), v, {25'b0, VEC[i].exp_pend});
      check($sformatf("R6/R7/R9 irq row %0d", i), {31'b0, irq_o}, {31'b0, VEC[i].exp_irq});
      check($sformatf("R9 no pulse row %0d", i), {31'b0, core_rst_o}, 32'h0);
    end

    // R2/R7: readback and unmapped offset
    step(1'b1, 8'h1C, 32'hFFFF_FFFF, 7'h00);
    rd(8'h1C, v); check("R7 gate readback", v, 32'h8000_0000);
    rd(8'h28, v); check("R2 mask readback", v, 32'h0000_007F);
    rd(8'h24, v); check("R2 unmapped read", v, 32'h0);

    // R9: key at wrong offset, near-miss key
    step(1'b1, 8'h20, 32'h0000_0000, 7'h12);
    step(1'b1, 8'h44, 32'h0000_000A, 7'h00);
    check("R9 key wrong offset", {31'b0, core_rst_o}, 32'h0);
    step(1'b1, 8'h40, 32'h0000_010A, 7'h00);
    check("R9 near key", {31'b0, core_rst_o}, 32'h0);
    rd(8'h28, v); check("R9 mask kept", v, 32'h0000_007F);
    rd(8'h20, v); check("R9 pend kept", v, 32'h0000_0012);
    check("R6 irq before key", {31'b0, irq_o}, 32'h1);

    // R8: exact key
    step(1'b1, 8'h40, 32'h0000_000A, 7'h00);
    n = 0;
    while (core_rst_o && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R8 pulse length", n, 16);
    rd(8'h1C, v); check("R8 gate cleared", v, 32'h0);
    rd(8'h28, v); check("R8 mask cleared", v, 32'h0);
    rd(8'h20, v); check("R8 pend cleared", v, 32'h0);
    check("R8 irq off", {31'b0, irq_o}, 32'h0);

    // R3: events latch after key reset though masked
    step(1'b0, 8'h00, 32'h0, 7'h08);
    rd(8'h20, v); check("R3 latch masked", v, 32'h0000_0008);
    check("R6 irq masked", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule